// File: doc/BRIEF.md
# I2C Master Status and Interrupt Register

This block holds the status and interrupt state of an I2C master controller. The master engine sends it single-cycle event pulses. These report that an address was sent, a byte finished, a stop was generated, a NACK was seen, arbitration was lost, a start or stop was detected on the bus, or a transfer was requested. The block keeps sticky flags for these events and drives a registered interrupt request.

Software reaches the block through one register of `REG_W` bits. A read returns the status flags. A write to the same bit positions acts as a set of write-1-to-clear strobes. While the interrupt flag is set, the engine is held, so the next sequence step waits until software clears the flag.

A transfer request made while the bus is busy is cancelled at once and reported as lost arbitration. Arbitration lost during addressing or data raises an SDA-release request. The bit shifting, clock generation and pin drivers live outside this block.

Top module: `i2cm_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every flag, `irq`, `hold`, `sda_release` and `xfer_cancel` are 0, and a selected read returns all zeros.
- R2: The interrupt flag, read at bit 7, is set on the clock edge after any of these pulses: `ev_addr_done`, `ev_byte_done`, `ev_stop_gen`, `ev_nack`, `ev_arb_lost`, or a cancelled transfer request.
- R3: A write with `sel` and `wr_en` high clears each flag at bits 7, 6 or 5 whose `wr_data` bit is 1. A write bit of 0, or a write without `sel`, leaves that flag unchanged.
- R4: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: `irq` is registered. On each edge it takes the new interrupt flag value ANDed with `irq_en` as sampled at that edge.
- R6: `hold` equals the interrupt flag, so the engine stalls from the edge that sets the flag until the edge that clears it.
- R7: `xfer_req` while the bus-busy bit is 1 drives `xfer_cancel` high in that same cycle. The arbitration-lost bit (bit 6) and the interrupt flag are then set on the next edge.
- R8: `ev_arb_lost` drives `sda_release` high in the same cycle and sets bit 6. `sda_release` stays high while bit 6 is set.
- R9: `ev_nack` sets the bus-error bit (bit 5) and the interrupt flag on the next edge.
- R10: The bus-busy bit (bit 4) is set by `ev_bus_start` and cleared by `ev_bus_stop` or reset. If both pulses arrive in one cycle, the bit is set. Writes never change it.
- R11: Bits 3 to 0 and every bit above 7 read as 0. When `sel` is low, `rd_data` is all zeros.
- R12: The bit 6 and bit 5 flags clear independently, so a write of 1 to one of them leaves the other one as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_addr_done | input | 1 | Pulse: address phase finished |
| ev_byte_done | input | 1 | Pulse: one data byte transferred |
| ev_stop_gen | input | 1 | Pulse: stop condition generated |
| ev_nack | input | 1 | Pulse: no acknowledge in an address or data cycle |
| ev_arb_lost | input | 1 | Pulse: arbitration lost during address or data |
| ev_bus_start | input | 1 | Pulse: start condition detected on the bus |
| ev_bus_stop | input | 1 | Pulse: stop condition detected on the bus |
| xfer_req | input | 1 | Pulse: engine requests a new transfer |
| irq_en | input | 1 | Interrupt enable |
| sel | input | 1 | Register address match |
| wr_en | input | 1 | Write enable |
| wr_data | input | REG_W | Write data; 1 bits are clear strobes |
| rd_data | output | REG_W | Status byte, combinational |
| irq | output | 1 | Registered interrupt request |
| hold | output | 1 | Stall request to the engine |
| xfer_cancel | output | 1 | Current transfer request is cancelled |
| sda_release | output | 1 | Request to stop driving SDA |

## Verification
The bench builds the block with the default `REG_W` of 8, so the whole status byte is visible. Directed phases cover reset, each event source, the write-0 and unselected-write cases, and same-cycle set and clear collisions. A long pseudo-random phase then drives sparse event pulses, transfer requests and clearing writes together. This reaches start and stop collisions, requests that land on a busy bus, and `irq_en` toggling while the flag changes.

// File: rtl/i2cm_status_pkg.sv
package i2cm_status_pkg;
  localparam int unsigned STS_BITS  = 8;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_LSB  = 5;
  localparam int unsigned BERR_IDX  = 0;
  localparam int unsigned ARB_IDX   = 1;
  localparam int unsigned INT_IDX   = 2;
  localparam int unsigned BUSY_BIT  = 4;

  typedef struct packed {
    logic int_f;
    logic arb_f;
    logic berr_f;
    logic busy_f;
  } status_t;
endpackage

// File: rtl/i2cm_sticky_flag.sv
module i2cm_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst) set |=> q);
  p_clear_r3:    assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !q);
endmodule

// File: rtl/i2cm_arb_guard.sv
module i2cm_arb_guard (
  input  logic xfer_req,
  input  logic bus_busy,
  input  logic ev_arb_lost,
  input  logic arb_flag,
  output logic req_lost,
  output logic arb_set,
  output logic sda_release
);
  always_comb begin
    req_lost    = xfer_req & bus_busy;
    arb_set     = req_lost | ev_arb_lost;
    sda_release = ev_arb_lost | arb_flag;
  end
endmodule

// File: rtl/i2cm_irq_gen.sv
module i2cm_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic flag_next,
  input  logic irq_en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag_next & irq_en;
  end
endmodule

// File: rtl/i2cm_status_ctrl.sv
module i2cm_status_ctrl
  import i2cm_status_pkg::*;
#(
  parameter int unsigned REG_W = STS_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_addr_done,
  input  logic             ev_byte_done,
  input  logic             ev_stop_gen,
  input  logic             ev_nack,
  input  logic             ev_arb_lost,
  input  logic             ev_bus_start,
  input  logic             ev_bus_stop,
  input  logic             xfer_req,
  input  logic             irq_en,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic             hold,
  output logic             xfer_cancel,
  output logic             sda_release
);
  localparam int unsigned PAD_W = REG_W - STS_BITS;

  logic                 wr_stb;
  logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_q;
  logic                 busy_q, arb_set, int_next;
  status_t              sts;

  assign wr_stb = sel & wr_en;

  i2cm_arb_guard u_arb (
    .xfer_req    (xfer_req),
    .bus_busy    (busy_q),
    .ev_arb_lost (ev_arb_lost),
    .arb_flag    (flg_q[ARB_IDX]),
    .req_lost    (xfer_cancel),
    .arb_set     (arb_set),
    .sda_release (sda_release)
  );

  always_comb begin
    flg_set[BERR_IDX] = ev_nack;
    flg_set[ARB_IDX]  = arb_set;
    flg_set[INT_IDX]  = ev_addr_done | ev_byte_done | ev_stop_gen | ev_nack | arb_set;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    assign flg_clr[g] = wr_stb & wr_data[FLAG_LSB + g];
    i2cm_sticky_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (flg_set[g]),
      .clr (flg_clr[g]),
      .q   (flg_q[g])
    );
  end

  i2cm_sticky_flag u_busy (
    .clk (clk),
    .rst (rst),
    .set (ev_bus_start),
    .clr (ev_bus_stop),
    .q   (busy_q)
  );

  assign int_next = flg_set[INT_IDX] | (flg_q[INT_IDX] & ~flg_clr[INT_IDX]);

  i2cm_irq_gen u_irq (
    .clk       (clk),
    .rst       (rst),
    .flag_next (int_next),
    .irq_en    (irq_en),
    .irq       (irq)
  );

  assign hold = flg_q[INT_IDX];

  always_comb begin
    sts.int_f  = flg_q[INT_IDX];
    sts.arb_f  = flg_q[ARB_IDX];
    sts.berr_f = flg_q[BERR_IDX];
    sts.busy_f = busy_q;
  end

  if (PAD_W > 0) begin : g_pad
    assign rd_data = sel ? {{PAD_W{1'b0}}, sts, 4'b0000} : '0;
  end else begin : g_nopad
    assign rd_data = sel ? {sts, 4'b0000} : '0;
  end

  p_cancel_flags_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_cancel |=> (rd_data[FLAG_LSB + ARB_IDX] || !sel) && hold);
  p_arb_release_r8: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> sda_release);
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> hold);
  p_nack_berr_r9: assert property (@(posedge clk) disable iff (rst)
    ev_nack |=> hold);
endmodule

// File: tb/i2cm_status_ctrl_bench.sv
module i2cm_status_ctrl_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic ev_addr_done = 0, ev_byte_done = 0, ev_stop_gen = 0, ev_nack = 0, ev_arb_lost = 0;
  logic ev_bus_start = 0, ev_bus_stop = 0, xfer_req = 0, irq_en = 0, sel = 0, wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic irq, hold, xfer_cancel, sda_release;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  int m_int = 0, m_arb = 0, m_berr = 0, m_busy = 0, m_irq = 0;

  always #10 clk = ~clk;

  i2cm_status_ctrl u_i2cm_status_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    exp_rd = sel ? ((m_int << 7) | (m_arb << 6) | (m_berr << 5) | (m_busy << 4)) : 0;
    chk("R2 int bit7", int'(rd_data[7]), sel ? m_int : 0);
    chk("R7 arb bit6", int'(rd_data[6]), sel ? m_arb : 0);
    chk("R9 berr bit5", int'(rd_data[5]), sel ? m_berr : 0);
    chk("R10 busy bit4", int'(rd_data[4]), sel ? m_busy : 0);
    chk("R11 whole read", int'(rd_data), exp_rd);
    chk("R5 irq", int'(irq), m_irq);
    chk("R6 hold", int'(hold), m_int);
    chk("R7 xfer_cancel", int'(xfer_cancel), int'(xfer_req) & m_busy);
    chk("R8 sda_release", int'(sda_release), int'(ev_arb_lost) | m_arb);
  endtask

  task automatic model_edge();
    int clr, arbset, setint;
    if (rst) begin
      m_int = 0; m_arb = 0; m_berr = 0; m_busy = 0; m_irq = 0;
      return;
    end
    clr    = (sel && wr_en) ? int'(wr_data) : 0;
    arbset = int'(ev_arb_lost) | (int'(xfer_req) & m_busy);
    setint = int'(ev_addr_done | ev_byte_done | ev_stop_gen | ev_nack) | arbset;
    m_int  = setint ? 1 : (clr[7] ? 0 : m_int);
    m_arb  = arbset ? 1 : (clr[6] ? 0 : m_arb);
    m_berr = ev_nack ? 1 : (clr[5] ? 0 : m_berr);
    m_busy = ev_bus_start ? 1 : (ev_bus_stop ? 0 : m_busy);
    m_irq  = m_int & int'(irq_en);
  endtask

  // one cycle: inputs already driven; compare at negedge, update model at posedge, clear pulses
  task automatic cyc();
    @(negedge clk);
    compare_all();
    @(posedge clk);
    model_edge();
    #1;
    {ev_addr_done, ev_byte_done, ev_stop_gen, ev_nack, ev_arb_lost} = '0;
    {ev_bus_start, ev_bus_stop, xfer_req, wr_en} = '0;
    wr_data = '0;
  endtask

  task automatic wr(logic [W-1:0] d);
    sel = 1; wr_en = 1; wr_data = d;
  endtask

  initial begin
    sel = 1;
    cyc(); cyc();
    rst = 0;
    // R1: reset state
    @(negedge clk);
    chk("R1 reset read", int'(rd_data), 0);
    chk("R1 reset irq/hold", int'({irq, hold, sda_release, xfer_cancel}), 0);
    @(posedge clk); #1;

    irq_en = 1;
    ev_addr_done = 1; cyc(); cyc();
    wr(8'h80); cyc();                 // R3 clear int
    ev_byte_done = 1; cyc();
    wr(8'h7F); cyc();                 // R3 write 0 to bit7: no effect
    @(negedge clk); chk("R3 write-0 keeps int", int'(rd_data[7]), 1); @(posedge clk); #1;
    sel = 0; wr_en = 1; wr_data = 8'hFF; cyc(); // R3 unselected write ignored
    sel = 1;
    @(negedge clk); chk("R3 unselected write ignored", int'(rd_data[7]), 1); @(posedge clk); #1;
    ev_stop_gen = 1; wr(8'h80); cyc(); // R4 set beats clear
    @(negedge clk); chk("R4 set wins", int'(rd_data[7]), 1); @(posedge clk); #1;
    wr(8'h80); cyc();
    ev_nack = 1; cyc();                // R9
    ev_arb_lost = 1; cyc();            // R8
    wr(8'h40); cyc();                  // R12 clear arb only
    @(negedge clk); chk("R12 berr kept", int'(rd_data[6:5]), 1); @(posedge clk); #1;
    wr(8'hE0); cyc();
    ev_bus_start = 1; cyc();           // R10
    wr(8'hF0); cyc();                  // R10 writes do not touch busy
    @(negedge clk); chk("R10 busy unaffected by write", int'(rd_data[4]), 1); @(posedge clk); #1;
    xfer_req = 1; cyc();               // R7 cancel
    wr(8'hC0); cyc();
    ev_bus_stop = 1; cyc();
    xfer_req = 1; cyc();               // R7 no cancel when idle
    ev_bus_start = 1; ev_bus_stop = 1; cyc(); // R10 both -> set
    @(negedge clk); chk("R10 start+stop sets busy", int'(rd_data[4]), 1); @(posedge clk); #1;
    irq_en = 0; ev_addr_done = 1; cyc(); cyc(); // R5 masked
    irq_en = 1; cyc();
    sel = 0; cyc();                    // R11 deselected read
    sel = 1;

    for (int i = 0; i < 4000; i++) begin
      ev_addr_done = ($urandom_range(15) == 0);
      ev_byte_done = ($urandom_range(15) == 0);
      ev_stop_gen  = ($urandom_range(31) == 0);
      ev_nack      = ($urandom_range(31) == 0);
      ev_arb_lost  = ($urandom_range(31) == 0);
      ev_bus_start = ($urandom_range(15) == 0);
      ev_bus_stop  = ($urandom_range(15) == 0);
      xfer_req     = ($urandom_range(15) == 0);
      irq_en       = ($urandom_range(7) != 0);
      sel          = ($urandom_range(7) != 0);
      wr_en        = ($urandom_range(3) == 0);
      wr_data      = W'($urandom);
      cyc();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule